// File: doc/BRIEF.md
# Condition and Carry Status Unit

This block keeps an eight-field, 32-bit condition register and the three fixed-point status flags: overflow, carry and a sticky summary overflow. An arithmetic unit reports its overflow and carry results through a status update port. A decoder watches a 32-bit instruction word, with bit 0 taken as the most significant bit. When the word is a sample-and-clear status move, the unit copies the three flags into one chosen 4-bit condition field and zeroes the flags in the same clock edge.

Software uses the move to learn whether an overflow has happened since the last time it looked. The flags are read into a condition field that a branch can test, and the move clears them so the next interval starts clean. The whole condition register, the three flags and a registered next-PC value are visible as outputs.

Top module: `cond_status_unit`

## Requirements
- R1: An instruction with `instr_valid_i` high is recognised when word bits 31:26 equal 31 and word bits 10:1 equal 512. Bits 22:11 and bit 0 have no effect on decoding. A word presented with `instr_valid_i` low changes no state. 0x7C000400 is a matching word.
- R2: A recognised instruction writes the condition field selected by word bits 25:23 (0 to 7). The field is written as {LT, GT, EQ, SO} = {summary overflow, overflow, carry, 0}, using the flag values from before the edge.
- R3: On the same edge as R2, the summary-overflow, overflow and carry flags all become 0.
- R4: A recognised instruction leaves the other seven condition fields unchanged. Field k sits at condition register bits [31-4k : 28-4k], with LT as the most significant bit of the field.
- R5: After a recognised instruction, `next_pc_o` equals `pc_i + 4` from the cycle the instruction was presented. Otherwise it holds its value.
- R6: When `upd_valid_i` is high and no instruction is recognised, overflow and carry load `upd_ov_i` and `upd_ca_i`. Summary overflow becomes set when `upd_ov_i` is 1 and otherwise keeps its value.
- R7: If a status update arrives in the same cycle as a recognised instruction, the instruction wins: the field gets the pre-edge flags and all three flags end at 0.
- R8: A non-matching word with `instr_valid_i` high leaves the condition register, the flags and `next_pc_o` unchanged. It raises `unrec_o` for exactly the following cycle.
- R9: While `rst_n` is low at a clock edge, the condition register, the flags, `next_pc_o` and `unrec_o` become 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid_i | input | 1 | Instruction word is present this cycle |
| instr_word_i | input | 32 | Instruction word, bit 0 numbered as MSB |
| pc_i | input | 32 | Address of the presented instruction |
| upd_valid_i | input | 1 | Status update from the arithmetic unit |
| upd_ov_i | input | 1 | Overflow result of the arithmetic operation |
| upd_ca_i | input | 1 | Carry result of the arithmetic operation |
| cr_o | output | 32 | Whole condition register, field 0 in the top nibble |
| so_o | output | 1 | Summary-overflow flag |
| ov_o | output | 1 | Overflow flag |
| ca_o | output | 1 | Carry flag |
| next_pc_o | output | 32 | Address following the last executed instruction |
| unrec_o | output | 1 | One-cycle pulse for an unrecognised valid word |

## Verification
Every piece of state is an output register, so a wrong internal value shows at the ports one edge after the stimulus that caused it. If the flag permutation is wrong, the target field shows the wrong bits on the very next cycle. A missing clear shows as a flag still set on that same cycle. A wrong field index shows as a changed neighbour field. A lost sticky bit shows on the first idle cycle after an update with no overflow. The scoreboard compares all outputs on every cycle, so none of these can stay hidden until a later read.

// File: rtl/csu_pkg.sv
// Package: shared sizes, decode constants and record types for the
// condition and carry status unit. Assumes 32-bit words, with bit 0
// taken as the MSB.
package csu_pkg;
    localparam int WORD_W      = 32;
    localparam int FIELD_W     = 4;
    localparam int FIELD_COUNT = 8;
    localparam int IDX_W       = $clog2(FIELD_COUNT);
    localparam int CR_W        = FIELD_W * FIELD_COUNT;
    localparam int PRIM_W      = 6;
    localparam int EXT_W       = 10;
    localparam logic [PRIM_W-1:0] PRIMARY_OP = 6'd31;
    localparam logic [EXT_W-1:0]  EXT_OP     = 10'd512;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cr_field_t;

    typedef struct packed {
        logic so;
        logic ov;
        logic ca;
    } status_t;
endpackage

// File: rtl/csu_decode.sv
// Module: csu_decode
// Recognises the sample-and-clear status move in a 32-bit instruction word
// and extracts the destination field index.
// Assumes: bit 0 of the word is its MSB. Bits 9..20 and bit 31 are ignored.
module csu_decode
    import csu_pkg::*;
(
    input  logic              valid_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              move_o,
    output logic              unrec_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int PRIM_LSB = WORD_W - PRIM_W;
    localparam int IDX_MSB  = PRIM_LSB - 1;

    logic [PRIM_W-1:0] prim;
    logic [EXT_W-1:0]  ext;
    logic              match;
    logic              unused_bits;

    // Field extraction for the primary opcode, the extended opcode and the index.
    always_comb begin
        prim  = word_i[WORD_W-1 -: PRIM_W];
        ext   = word_i[EXT_W:1];
        idx_o = word_i[IDX_MSB -: IDX_W];
        match = (prim == PRIMARY_OP) && (ext == EXT_OP);
    end

    assign unused_bits = ^{word_i[IDX_MSB-IDX_W:EXT_W+1], word_i[0]};

    // Qualify the match with the valid strobe.
    always_comb begin
        move_o  = valid_i && match;
        unrec_o = valid_i && !match;
    end
endmodule

// File: rtl/csu_status.sv
// Module: csu_status
// Holds the overflow, carry and sticky summary-overflow flags.
// Assumes: a clear request outranks an arithmetic update on the same edge.
module csu_status
    import csu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear_i,
    input  logic    upd_valid_i,
    input  logic    upd_ov_i,
    input  logic    upd_ca_i,
    output status_t flags_o
);
    status_t flags_q;

    // Flag register: reset, clear, or load with the sticky summary bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (clear_i) begin
            flags_q <= '0;
        end else if (upd_valid_i) begin
            flags_q.ov <= upd_ov_i;
            flags_q.ca <= upd_ca_i;
            flags_q.so <= flags_q.so | upd_ov_i;
        end
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/csu_cond_reg.sv
// Module: csu_cond_reg
// Condition register built from FIELD_COUNT independently written fields.
// Assumes: field 0 occupies the top nibble, and at most one field is written per edge.
module csu_cond_reg
    import csu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  cr_field_t        wr_data_i,
    output logic [CR_W-1:0]  cr_o
);
    for (genvar g = 0; g < FIELD_COUNT; g++) begin : g_field
        cr_field_t field_q;

        // Per-field storage: loaded only when this field is the target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                field_q <= '0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                field_q <= wr_data_i;
            end
        end

        assign cr_o[CR_W-1-g*FIELD_W -: FIELD_W] = field_q;
    end
endmodule

// File: rtl/cond_status_unit.sv
// Module: cond_status_unit (top)
// Decodes the sample-and-clear status move and holds the condition register,
// the status flags, the next-PC value and the unrecognised-word pulse.
// Assumes: one instruction per cycle; the PC step is fixed by PC_STEP.
module cond_status_unit
    import csu_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid_i,
    input  logic [WORD_W-1:0] instr_word_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic              upd_valid_i,
    input  logic              upd_ov_i,
    input  logic              upd_ca_i,
    output logic [CR_W-1:0]   cr_o,
    output logic              so_o,
    output logic              ov_o,
    output logic              ca_o,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              unrec_o
);
    logic             move;
    logic             unrec;
    logic [IDX_W-1:0] idx;
    status_t          flags;
    cr_field_t        wr_data;
    logic [PC_W-1:0]  npc_q;
    logic             unrec_q;

    csu_decode u_decode (
        .valid_i (instr_valid_i),
        .word_i  (instr_word_i),
        .move_o  (move),
        .unrec_o (unrec),
        .idx_o   (idx)
    );

    csu_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (move),
        .upd_valid_i (upd_valid_i),
        .upd_ov_i    (upd_ov_i),
        .upd_ca_i    (upd_ca_i),
        .flags_o     (flags)
    );

    // Permute the pre-edge flags into the field layout.
    always_comb begin
        wr_data.lt = flags.so;
        wr_data.gt = flags.ov;
        wr_data.eq = flags.ca;
        wr_data.so = 1'b0;
    end

    csu_cond_reg u_cr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (move),
        .wr_idx_i  (idx),
        .wr_data_i (wr_data),
        .cr_o      (cr_o)
    );

    // Next-PC register and the one-cycle unrecognised-word pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            npc_q   <= '0;
            unrec_q <= 1'b0;
        end else begin
            unrec_q <= unrec;
            if (move) npc_q <= pc_i + PC_W'(PC_STEP);
        end
    end

    assign so_o      = flags.so;
    assign ov_o      = flags.ov;
    assign ca_o      = flags.ca;
    assign next_pc_o = npc_q;
    assign unrec_o   = unrec_q;
endmodule

// File: rtl/csu_checker.sv
// Module: csu_checker
// Temporal properties for cond_status_unit, written on its ports only.
// Assumes: synchronous active-low reset; all checks are disabled while it is low.
module csu_checker
    import csu_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid_i,
    input logic [WORD_W-1:0] instr_word_i,
    input logic [PC_W-1:0]   pc_i,
    input logic              upd_valid_i,
    input logic              upd_ov_i,
    input logic [CR_W-1:0]   cr_o,
    input logic              so_o,
    input logic              ov_o,
    input logic              ca_o,
    input logic [PC_W-1:0]   next_pc_o,
    input logic              unrec_o
);
    logic             hit;
    logic [IDX_W-1:0] idx_q;
    logic [FIELD_W-1:0] sel_field;
    logic [CR_W-1:0]  keep_mask;

    assign hit = instr_valid_i && (instr_word_i[31:26] == PRIMARY_OP)
                 && (instr_word_i[10:1] == EXT_OP);

    // Remember the index that was presented on the previous cycle.
    always_ff @(posedge clk) idx_q <= instr_word_i[25:23];

    assign sel_field = FIELD_W'(cr_o >> (CR_W - FIELD_W - FIELD_W * int'(idx_q)));
    assign keep_mask = ~({{FIELD_W{1'b1}}, {(CR_W-FIELD_W){1'b0}}} >> (FIELD_W * int'(idx_q)));

    p_field_perm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> sel_field == {$past(so_o), $past(ov_o), $past(ca_o), 1'b0});

    p_flags_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (!so_o && !ov_o && !ca_o));

    p_others_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ((cr_o & keep_mask) == ($past(cr_o) & keep_mask)));

    p_next_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> next_pc_o == $past(pc_i) + PC_W'(PC_STEP));

    p_sticky_so_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (so_o && !hit) |=> so_o);

    p_so_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_i && upd_ov_i && !hit) |=> so_o);

    p_unrec_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_i && !hit) |=> (unrec_o && $stable(cr_o) && $stable(next_pc_o)));

    p_no_unrec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_valid_i && !hit) |=> !unrec_o);
endmodule

bind cond_status_unit csu_checker #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_csu_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid_i (instr_valid_i),
    .instr_word_i  (instr_word_i),
    .pc_i          (pc_i),
    .upd_valid_i   (upd_valid_i),
    .upd_ov_i      (upd_ov_i),
    .cr_o          (cr_o),
    .so_o          (so_o),
    .ov_o          (ov_o),
    .ca_o          (ca_o),
    .next_pc_o     (next_pc_o),
    .unrec_o       (unrec_o)
);

// File: tb/cond_status_unit_tb_top.sv
// Scoreboard bench: the driver applies one cycle of stimulus, updates a
// reference model built from the requirements and queues the expected outputs.
// The monitor pops the queue after each rising edge and compares.
module cond_status_unit_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid_i = 1'b0;
    logic [31:0] instr_word_i = '0;
    logic [31:0] pc_i = '0;
    logic        upd_valid_i = 1'b0;
    logic        upd_ov_i = 1'b0;
    logic        upd_ca_i = 1'b0;
    logic [31:0] cr_o;
    logic        so_o, ov_o, ca_o, unrec_o;
    logic [31:0] next_pc_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Expected item: {cr, so, ov, ca, next_pc, unrec}
    logic [67:0] exp_q[$];
    string       tag_q[$];

    // Reference model state
    logic [31:0] m_cr = '0;
    logic        m_so = 0, m_ov = 0, m_ca = 0, m_unrec = 0;
    logic [31:0] m_npc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_status_unit dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i),
        .instr_word_i(instr_word_i), .pc_i(pc_i), .upd_valid_i(upd_valid_i),
        .upd_ov_i(upd_ov_i), .upd_ca_i(upd_ca_i), .cr_o(cr_o), .so_o(so_o),
        .ov_o(ov_o), .ca_o(ca_o), .next_pc_o(next_pc_o), .unrec_o(unrec_o)
    );

    // Matching word: primary 31, index in bits 25:23, ignored bits, extended 512.
    function automatic logic [31:0] mk_move(input logic [2:0] idx,
                                            input logic [11:0] junk,
                                            input logic lastbit);
        return {6'd31, idx, junk, 10'd512, lastbit};
    endfunction

    // One cycle of stimulus plus the model update (R1..R9).
    task automatic step(input logic rst, input logic v, input logic [31:0] w,
                        input logic [31:0] pc, input logic uv, input logic uo,
                        input logic uc, input string tag);
        logic hit;
        @(negedge clk);
        rst_n = rst; instr_valid_i = v; instr_word_i = w; pc_i = pc;
        upd_valid_i = uv; upd_ov_i = uo; upd_ca_i = uc;
        hit = v && (w[31:26] == 6'd31) && (w[10:1] == 10'd512);
        if (!rst) begin
            m_cr = '0; m_so = 0; m_ov = 0; m_ca = 0; m_npc = '0; m_unrec = 0;
        end else begin
            m_unrec = v && !hit;
            if (hit) begin
                for (int b = 0; b < 4; b++)
                    m_cr[31 - 4*int'(w[25:23]) - b] = (b == 0) ? m_so :
                                                     (b == 1) ? m_ov :
                                                     (b == 2) ? m_ca : 1'b0;
                m_so = 0; m_ov = 0; m_ca = 0;
                m_npc = pc + 32'd4;
            end else if (uv) begin
                m_ov = uo; m_ca = uc; m_so = m_so | uo;
            end
        end
        exp_q.push_back({m_cr, m_so, m_ov, m_ca, m_npc, m_unrec});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b1, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compare every queued expectation just after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                logic [67:0] e, a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {cr_o, so_o, ov_o, ca_o, next_pc_o, unrec_o};
                total++;
                if (a !== e) begin
                    bad++;
                    $display("FAIL %s: actual cr=%h so/ov/ca=%b%b%b npc=%h unrec=%b expected cr=%h so/ov/ca=%b%b%b npc=%h unrec=%b",
                             t, a[67:36], a[35], a[34], a[33], a[32:1], a[0],
                             e[67:36], e[35], e[34], e[33], e[32:1], e[0]);
                end
            end
        end
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Driver sequence.
    initial begin
        step(1'b0, 0, '0, '0, 0, 0, 0, "R9 reset");
        step(1'b0, 1, 32'h7C000400, 32'h100, 1, 1, 1, "R9 reset holds zero");
        // R6: load flags, summary overflow sets
        step(1'b1, 0, '0, '0, 1, 1, 1, "R6 update sets so/ov/ca");
        step(1'b1, 0, '0, '0, 1, 0, 0, "R6 sticky so after no-overflow update");
        // R2 R3 R5: canonical word, field 0
        step(1'b1, 1, 32'h7C000400, 32'h0000_1000, 0, 0, 0, "R2 R3 R5 canonical move to field 0");
        // R1 R4: ignored bits set, field 5
        step(1'b1, 0, '0, '0, 1, 1, 1, "R6 update before move");
        step(1'b1, 1, mk_move(3'd5, 12'hFFF, 1'b1), 32'h0000_2000, 0, 0, 0, "R1 R4 move field 5 with ignored bits set");
        // R7: update in same cycle as move
        step(1'b1, 0, '0, '0, 1, 0, 1, "R6 carry only");
        step(1'b1, 1, mk_move(3'd7, 12'h5A5, 1'b0), 32'h0000_3000, 1, 1, 1, "R7 move wins over update");
        idle("R7 flags stay clear");
        // R8: non-matching valid words
        step(1'b1, 0, '0, '0, 1, 1, 0, "R6 set before bad word");
        step(1'b1, 1, {6'd31, 3'd2, 12'd0, 10'd511, 1'b0}, 32'h0000_4000, 0, 0, 0, "R8 wrong extended opcode");
        step(1'b1, 1, {6'd30, 3'd2, 12'd0, 10'd512, 1'b0}, 32'h0000_5000, 0, 0, 0, "R8 wrong primary opcode");
        idle("R8 pulse drops");
        // R1: matching word without valid
        step(1'b1, 0, mk_move(3'd2, 12'h000, 1'b0), 32'h0000_6000, 0, 0, 0, "R1 word ignored without valid");
        // R2 R4: sweep all fields with changing flags
        for (int k = 0; k < 8; k++) begin
            step(1'b1, 0, '0, '0, 1, k[0], k[1], "R6 sweep update");
            step(1'b1, 1, mk_move(k[2:0], 12'(k * 291), k[0]), 32'h0001_0000 + 32'(k * 8),
                 0, 0, 0, "R2 R4 R5 field sweep");
        end
        step(1'b0, 0, '0, '0, 0, 0, 0, "R9 reset after traffic");
        idle("R9 state after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule